// File: doc/BRIEF.md
# Endian-Configurable Byte-Addressed Memory

This block is a small synchronous data memory addressed in bytes. It serves byte, 16-bit halfword and 32-bit word loads and stores through one request port. A single static input chooses how the bytes of a multi-byte value are spread across consecutive byte addresses. With big-endian ordering the lowest address of the access holds the most significant byte. With little-endian ordering it holds the least significant byte. Each byte address always names the same stored byte, whichever ordering is in force.

A request is presented for one clock cycle. A store changes exactly the bytes it covers. A load returns its value zero-extended into the 32-bit read data one cycle later. An access that does not start on a multiple of its own size, or that uses the reserved size code, raises an error pulse. Such an access writes nothing and returns zero data. Storage is organised as one byte-wide array per lane, so each lane maps onto a block RAM. Word addresses beyond the configured depth wrap around.

Top module: `endian_byte_mem`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rdata_o` is zero and `err_o` is low.
- R2: A byte load (size code 2'b00) at any address returns that address's byte in bits 7:0, with bits 31:8 zero.
- R3: With `big_endian_i` low, a halfword or word at byte address A places the byte at A in bits 7:0, A+1 in bits 15:8, A+2 in bits 23:16 and A+3 in bits 31:24, for both loads and stores; halfword loads leave bits 31:16 zero.
- R4: With `big_endian_i` high, the byte at the lowest address of the access occupies the most significant byte of the value: bits 31:24 for a word (size 2'b10) and bits 15:8 for a halfword (size 2'b01), for both loads and stores.
- R5: A halfword at an odd address, or a word at an address whose two low bits are not 00, raises `err_o` for exactly the cycle after the request, with `rdata_o` zero in that cycle.
- R6: Size code 2'b11 is rejected at every address in the same way as a misaligned access.
- R7: A rejected store leaves every stored byte unchanged.
- R8: An accepted store changes only the 1, 2 or 4 bytes it addresses; neighbouring bytes keep their contents.
- R9: A load leaves memory unchanged, so repeating it returns the same value.
- R10: Load data appears on `rdata_o` in the cycle after the request and only then; in a cycle after a store or after no request, `rdata_o` is zero.
- R11: The word index is the byte address divided by 4, taken modulo `DEPTH_WORDS`, so addresses beyond the depth alias onto lower ones.
- R12: Stored bytes belong to byte addresses and not to an ordering, so a word stored under one setting of `big_endian_i` reads back byte-reversed under the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| big_endian_i | input | 1 | 1: lowest address holds the most significant byte; 0: least significant |
| req_valid_i | input | 1 | Request present this cycle |
| wr_en_i | input | 1 | 1: store, 0: load |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved (rejected) |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store value, right-aligned (byte in 7:0, halfword in 15:0) |
| rdata_o | output | 32 | Load value, zero-extended, valid the cycle after the request |
| err_o | output | 1 | One-cycle pulse for a misaligned or reserved-size request |

## Verification
The bench sweeps every byte, even-halfword and word address of a small memory under both orderings. It compares each result against a byte model whose values are built by shifting. A design that swapped the lane order, or applied the ordering to single bytes, would return mirrored values. The bench tries every size and offset pair, including the reserved code, as both loads and stores, and then re-reads the neighbouring words. Steering that leaked a misaligned or partial store into an adjacent lane shows up there as corrupted bytes. The bench also covers addresses above the depth, stores made under one ordering and read under the other, and idle cycles after loads. These catch a missing address wrap, storage that depends on the ordering, and read data left stale on the output.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

endpackage

// File: rtl/ebm_align_chk.sv
module ebm_align_chk
  import ebm_pkg::*;
(
  input  logic [1:0] sz_i,
  input  logic [1:0] off_i,
  output logic       bad_o
);

  always_comb begin
    unique case (acc_size_e'(sz_i))
      SZ_BYTE: bad_o = 1'b0;
      SZ_HALF: bad_o = off_i[0];
      SZ_WORD: bad_o = |off_i;
      default: bad_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/ebm_store_steer.sv
module ebm_store_steer
  import ebm_pkg::*;
(
  input  logic              big_endian_i,
  input  logic [1:0]        sz_i,
  input  logic [1:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  lane_mask_o,
  output logic [DATA_W-1:0] lane_data_o
);

  int nbytes;
  int base;
  int pos;
  int src;

  always_comb begin
    lane_mask_o = '0;
    lane_data_o = '0;
    nbytes = (sz_i == SZ_RSVD) ? 0 : (1 << sz_i);
    base   = int'(off_i);
    pos    = 0;
    src    = 0;
    for (int k = 0; k < LANES; k++) begin
      pos = k - base;
      if (pos >= 0 && pos < nbytes) begin
        src = big_endian_i ? (nbytes - 1 - pos) : pos;
        lane_mask_o[k] = 1'b1;
        lane_data_o[k*LANE_W +: LANE_W] = wdata_i[src*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/ebm_load_pack.sv
module ebm_load_pack
  import ebm_pkg::*;
(
  input  logic              big_endian_i,
  input  logic [1:0]        sz_i,
  input  logic [1:0]        off_i,
  input  logic [DATA_W-1:0] lanes_i,
  output logic [DATA_W-1:0] data_o
);

  int nbytes;
  int dst;
  int lane;

  always_comb begin
    data_o = '0;
    nbytes = (sz_i == SZ_RSVD) ? 0 : (1 << sz_i);
    dst    = 0;
    lane   = 0;
    for (int i = 0; i < LANES; i++) begin
      if (i < nbytes) begin
        dst  = big_endian_i ? (nbytes - 1 - i) : i;
        lane = (int'(off_i) + i) % LANES;
        data_o[dst*LANE_W +: LANE_W] = lanes_i[lane*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/ebm_byte_bank.sv
module ebm_byte_bank
  import ebm_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] wbyte_i,
  output logic [LANE_W-1:0] rbyte_o
);

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[idx_i] <= wbyte_i;
    end
    if (rd_en_i) begin
      rbyte_o <= mem[idx_i];
    end
  end

endmodule

// File: rtl/endian_byte_mem.sv
module endian_byte_mem
  import ebm_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian_i,
  input  logic              req_valid_i,
  input  logic              wr_en_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);

  localparam int IDX_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;
  localparam int WA_W  = ADDR_W - 2;

  // address split and wrap
  logic [WA_W-1:0]  word_addr;
  logic [IDX_W-1:0] word_idx;
  logic [1:0]       byte_off;

  assign word_addr = addr_i[ADDR_W-1:2];
  assign byte_off  = addr_i[1:0];
  assign word_idx  = IDX_W'(word_addr % WA_W'(DEPTH_WORDS));

  // alignment
  logic misfit;
  logic acc_ok;
  logic do_wr;
  logic do_rd;

  ebm_align_chk u_align (
    .sz_i  (size_i),
    .off_i (byte_off),
    .bad_o (misfit)
  );

  assign acc_ok = req_valid_i & ~misfit;
  assign do_wr  = acc_ok & wr_en_i;
  assign do_rd  = acc_ok & ~wr_en_i;

  // store steering
  logic [LANES-1:0]  lane_mask;
  logic [DATA_W-1:0] lane_wdata;
  logic [DATA_W-1:0] lane_rdata;

  ebm_store_steer u_steer (
    .big_endian_i (big_endian_i),
    .sz_i         (size_i),
    .off_i        (byte_off),
    .wdata_i      (wdata_i),
    .lane_mask_o  (lane_mask),
    .lane_data_o  (lane_wdata)
  );

  // one byte-wide array per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ebm_byte_bank #(
      .DEPTH (DEPTH_WORDS),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk     (clk),
      .wr_en_i (do_wr & lane_mask[g]),
      .rd_en_i (do_rd),
      .idx_i   (word_idx),
      .wbyte_i (lane_wdata[g*LANE_W +: LANE_W]),
      .rbyte_o (lane_rdata[g*LANE_W +: LANE_W])
    );
  end

  // request context for the returning load
  logic       ld_q;
  logic       err_q;
  logic       be_q;
  logic [1:0] sz_q;
  logic [1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q  <= 1'b0;
      err_q <= 1'b0;
      be_q  <= 1'b0;
      sz_q  <= 2'b00;
      off_q <= 2'b00;
    end else begin
      ld_q  <= do_rd;
      err_q <= req_valid_i & misfit;
      if (do_rd) begin
        be_q  <= big_endian_i;
        sz_q  <= size_i;
        off_q <= byte_off;
      end
    end
  end

  logic [DATA_W-1:0] packed_rd;

  ebm_load_pack u_pack (
    .big_endian_i (be_q),
    .sz_i         (sz_q),
    .off_i        (off_q),
    .lanes_i      (lane_rdata),
    .data_o       (packed_rd)
  );

  assign rdata_o = ld_q ? packed_rd : '0;
  assign err_o   = err_q;

  // checks
  p_err_zero_data_r5: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (rdata_o == '0));

  p_err_after_req_r5: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(req_valid_i));

  p_rsvd_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && size_i == 2'b11) |=> err_o);

  p_mask_width_r8: assert property (@(posedge clk) disable iff (rst)
    acc_ok |-> ($countones(lane_mask) == (1 << size_i)));

  p_store_no_data_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && wr_en_i) |=> (rdata_o == '0));

  p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (do_rd && size_i == 2'b00) |=> (rdata_o[31:8] == '0));

endmodule

// File: tb/tb_endian_byte_mem.sv
`timescale 1ns/1ps
module tb_endian_byte_mem;

  localparam int ADDR_W = 12;
  localparam int DEPTH  = 64;
  localparam int BYTES  = DEPTH * 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              big_endian;
  logic              req;
  logic              wr;
  logic [1:0]        size;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata_o;
  logic              err_o;

  always #10 clk = ~clk;

  endian_byte_mem #(.DEPTH_WORDS(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk          (clk),
    .rst          (rst),
    .big_endian_i (big_endian),
    .req_valid_i  (req),
    .wr_en_i      (wr),
    .size_i       (size),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .rdata_o      (rdata_o),
    .err_o        (err_o)
  );

  logic [7:0] mdl [BYTES];
  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_bad(logic [1:0] sz, logic [ADDR_W-1:0] a);
    if (sz == 2'b11) return 1'b1;
    return (int'(a) % (1 << sz)) != 0;
  endfunction

  function automatic logic [31:0] mdl_load(bit be, logic [1:0] sz, logic [ADDR_W-1:0] a);
    logic [31:0] v = '0;
    int n = 1 << sz;
    for (int i = 0; i < n; i++) begin
      int sh = be ? 8 * (n - 1 - i) : 8 * i;
      v = v | (32'(mdl[(int'(a) + i) % BYTES]) << sh);
    end
    return v;
  endfunction

  task automatic mdl_store(bit be, logic [1:0] sz, logic [ADDR_W-1:0] a, logic [31:0] wd);
    int n = 1 << sz;
    for (int i = 0; i < n; i++) begin
      int sh = be ? 8 * (n - 1 - i) : 8 * i;
      mdl[(int'(a) + i) % BYTES] = 8'(wd >> sh);
    end
  endtask

  task automatic acc(bit be, bit we, logic [1:0] sz, logic [ADDR_W-1:0] a,
                     logic [31:0] wd, string tag, output logic [31:0] rd);
    bit e;
    @(negedge clk);
    big_endian = be; req = 1'b1; wr = we; size = sz; addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    rd = rdata_o;
    e  = is_bad(sz, a);
    chk({tag, " err_o"}, 32'(err_o), 32'(e));
    if (e || we) chk({tag, " rdata zero"}, rdata_o, 32'h0);
    else         chk({tag, " load value"}, rdata_o, mdl_load(be, sz, a));
    if (!e && we) mdl_store(be, sz, a, wd);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rd2;
    rst = 1'b1; big_endian = 1'b0; req = 1'b0; wr = 1'b0;
    size = 2'b00; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata_o, 32'h0);
    chk("R1 err in reset", 32'(err_o), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", rdata_o, 32'h0);
    chk("R1 err after reset", 32'(err_o), 32'h0);

    // fill with little-endian word stores
    for (int w = 0; w < DEPTH; w++)
      acc(1'b0, 1'b1, 2'b10, ADDR_W'(w * 4), 32'hA5C3_1E00 ^ (32'(w) * 32'h0103_0507), "R3 fill", rd);

    // literal orientation checks
    acc(1'b0, 1'b1, 2'b10, 12'h010, 32'h0A0B_0C0D, "R3 store", rd);
    acc(1'b0, 1'b0, 2'b00, 12'h010, 32'h0, "R3 byte", rd);
    chk("R3 lowest addr is LSB", rd, 32'h0000_000D);
    acc(1'b1, 1'b0, 2'b01, 12'h010, 32'h0, "R4 half", rd);
    chk("R4 half lowest addr is MSB", rd, 32'h0000_0D0C);
    acc(1'b1, 1'b1, 2'b10, 12'h014, 32'h1122_3344, "R4 store", rd);
    acc(1'b0, 1'b0, 2'b00, 12'h014, 32'h0, "R4 byte", rd);
    chk("R4 lowest addr holds 31:24", rd, 32'h0000_0011);

    // byte sweep, both orderings
    for (int a = 0; a < BYTES; a++) begin
      acc(1'b0, 1'b0, 2'b00, ADDR_W'(a), 32'h0, "R2 byte LE", rd);
      acc(1'b1, 1'b0, 2'b00, ADDR_W'(a), 32'h0, "R2 byte BE", rd);
    end
    // halfword and word load sweeps
    for (int a = 0; a < BYTES; a += 2) begin
      acc(1'b0, 1'b0, 2'b01, ADDR_W'(a), 32'h0, "R3 half LE", rd);
      acc(1'b1, 1'b0, 2'b01, ADDR_W'(a), 32'h0, "R4 half BE", rd);
    end
    for (int a = 0; a < BYTES; a += 4) begin
      acc(1'b0, 1'b0, 2'b10, ADDR_W'(a), 32'h0, "R3 word LE", rd);
      acc(1'b1, 1'b0, 2'b10, ADDR_W'(a), 32'h0, "R4 word BE", rd);
    end

    // partial stores with neighbour readback
    for (int w = 4; w < 12; w++) begin
      for (int o = 0; o < 4; o++) begin
        acc(w[0], 1'b1, 2'b00, ADDR_W'(w * 4 + o), 32'hFFFF_FF00 | 32'(w * 16 + o), "R8 byte store", rd);
        acc(1'b0, 1'b0, 2'b10, ADDR_W'(w * 4), 32'h0, "R8 byte neighbours", rd);
      end
      for (int o = 0; o < 4; o += 2) begin
        acc(w[1], 1'b1, 2'b01, ADDR_W'(w * 4 + o), 32'hDEAD_0000 | 32'(w * 257 + o), "R8 half store", rd);
        acc(1'b1, 1'b0, 2'b10, ADDR_W'(w * 4), 32'h0, "R8 half neighbours", rd);
        acc(1'b0, 1'b0, 2'b10, ADDR_W'(w * 4 - 4), 32'h0, "R8 prev word", rd);
        acc(1'b0, 1'b0, 2'b10, ADDR_W'(w * 4 + 4), 32'h0, "R8 next word", rd);
      end
    end

    // misaligned and reserved sizes, loads and stores
    for (int s = 1; s < 4; s++) begin
      for (int o = 0; o < 4; o++) begin
        for (int b = 0; b < 2; b++) begin
          if (s == 3) begin
            acc(b[0], 1'b0, 2'(s), ADDR_W'(64 + o), 32'h0, "R6 rsvd load", rd);
            acc(b[0], 1'b1, 2'(s), ADDR_W'(64 + o), 32'hBADB_AD00, "R6 rsvd store", rd);
          end else begin
            acc(b[0], 1'b0, 2'(s), ADDR_W'(64 + o), 32'h0, "R5 align load", rd);
            acc(b[0], 1'b1, 2'(s), ADDR_W'(64 + o), 32'h5A5A_5A5A, "R5 align store", rd);
          end
          acc(1'b0, 1'b0, 2'b10, ADDR_W'(64), 32'h0, "R7 word after", rd);
          acc(1'b0, 1'b0, 2'b10, ADDR_W'(68), 32'h0, "R7 next after", rd);
        end
      end
    end
    // error pulse lasts one cycle
    acc(1'b0, 1'b0, 2'b10, 12'h082, 32'h0, "R5 pulse", rd);
    @(negedge clk);
    chk("R5 err drops after one cycle", 32'(err_o), 32'h0);

    // repeated load
    acc(1'b1, 1'b0, 2'b10, 12'h030, 32'h0, "R9 first", rd);
    acc(1'b1, 1'b0, 2'b10, 12'h030, 32'h0, "R9 second", rd2);
    chk("R9 repeat equal", rd2, rd);

    // latency: data only in the cycle after the request
    acc(1'b0, 1'b0, 2'b10, 12'h010, 32'h0, "R10 load", rd);
    @(negedge clk);
    chk("R10 idle cycle zero", rdata_o, 32'h0);

    // wrap
    acc(1'b0, 1'b1, 2'b00, ADDR_W'(BYTES + 5), 32'h0000_00C7, "R11 high store", rd);
    acc(1'b0, 1'b0, 2'b00, 12'h005, 32'h0, "R11 alias", rd);
    chk("R11 alias literal", rd, 32'h0000_00C7);
    acc(1'b1, 1'b1, 2'b10, 12'hFFC, 32'hCAFE_F00D, "R11 top store", rd);
    acc(1'b1, 1'b0, 2'b10, ADDR_W'(BYTES - 4), 32'h0, "R11 top alias", rd);
    chk("R11 top alias literal", rd, 32'hCAFE_F00D);

    // ordering switch
    acc(1'b0, 1'b1, 2'b10, 12'h040, 32'h1122_3344, "R12 store LE", rd);
    acc(1'b1, 1'b0, 2'b10, 12'h040, 32'h0, "R12 load BE", rd);
    chk("R12 reversed", rd, 32'h4433_2211);
    acc(1'b1, 1'b1, 2'b01, 12'h046, 32'hABCD, "R12 half BE", rd);
    acc(1'b0, 1'b0, 2'b01, 12'h046, 32'h0, "R12 half LE", rd);
    chk("R12 half reversed", rd, 32'h0000_CDAB);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule